// File: doc/BRIEF.md
# RTC Time Register Snapshot and Commit Controller

This block stands between a free-running time-of-day counter chain and the time registers a host sees. It holds a user copy of seven time fields (seconds, minutes, hours, day of week, date, month, year) and refreshes that copy from the live counters whenever the counter chain signals a seconds tick. Setting a freeze bit stops the refreshes, so the host can read a consistent snapshot while the counters keep running. Setting a set-time bit also stops them. The host can then stage new time values. Clearing that bit hands all seven staged fields to the counter chain in one strobe.

The host reaches the block through a synchronous bus with a chip select, a write enable, a 3-bit register index and 8-bit data. Index 0 is the control register: bit 7 is the set-time bit, bit 6 is the freeze bit, and bits 5..0 are stored for a separate calibration block. Indices 1 to 7 are the time fields, ordered seconds, minutes, hours, day, date, month, year. Some flag bits live in the time fields and can be written at any time: the oscillator stop flag in seconds bit 7, and the frequency-test and century-enable flags in day bits 6 and 5.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: When neither control bit 7 nor bit 6 is set, a cycle with `live_tick_i` high copies all seven fields of `live_time_i` into the user registers at that edge. The byte for index i is `live_time_i[8*(i-1) +: 8]`. Seconds bit 7 and day bits 7..3 are excluded from the copy.
- R2: While control bit 6 (freeze) is 1, ticks do not change the time fields. The fields keep the values that were current when the freeze was written.
- R3: A write that sets the freeze bit in the same cycle as a tick does not block that tick's update. All seven fields take the new values.
- R4: While control bit 7 (set-time) is 1, ticks do not change the time fields. Host writes to indices 1..7 are stored in the time fields and read back.
- R5: A control write that clears bit 7 while it was 1 makes `load_stb_o` high for exactly the next cycle. During that cycle `load_time_o` carries the seven staged fields in the R1 byte layout, with the flag bits excluded.
- R6: After the freeze or set-time bit is cleared, the time fields stay unchanged until the next tick, and that tick refreshes them.
- R7: After reset, the control register, the time fields and all flags are 0, `osc_en_o` is 1 and `load_stb_o` is 0.
- R8: Seconds bit 7 is the stop flag. It is written by any write to index 1, whatever the set-time bit says. It reads back in seconds bit 7, and `osc_en_o` is its inverse.
- R9: Day bit 6 (frequency test, `freq_test_o`) and day bit 5 (century enable, `century_en_o`) are written by any write to index 4 and read back in place. They survive refreshes. While the set-time bit is 0, writes to the time bits of indices 1..7 are ignored.
- R10: Control bits 5..0 are stored on a control write, read back unchanged and driven on `cal_o`.
- R11: Read data for a read access (`bus_cs_i`=1, `bus_we_i`=0) appears on `bus_rdata_o` in the cycle after the access. It holds its value in cycles with no read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_i | input | 1 | Register access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register index (0 control, 1..7 time fields) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| live_time_i | input | 56 | Live counter fields, index i at bits 8*(i-1)+7..8*(i-1) |
| live_tick_i | input | 1 | One-cycle pulse when the live counters advance |
| load_stb_o | output | 1 | One-cycle strobe to load the counters |
| load_time_o | output | 56 | Staged fields for loading, same layout as live_time_i |
| osc_en_o | output | 1 | Oscillator enable (inverse of stop flag) |
| freq_test_o | output | 1 | Frequency-test flag |
| century_en_o | output | 1 | Century-enable flag |
| cal_o | output | 6 | Stored calibration bits of the control register |

## Verification
Ticks are driven with distinct live field values in four states: free-running, frozen, staging, and the single cycle in which the freeze write and a tick coincide. A changed readback then shows whether a refresh was taken or blocked, and the coincident case separates "a halt blocks an update already due" from "a halt only blocks later ticks". The field values stay different from each other across ticks, so a byte routed to the wrong index shows up. The flag bits are written with the set-time bit both cleared and set, and then read across refreshes. This separates flags that are stored apart from the time fields from flags that ride in the mirrored bytes. The commit strobe is sampled in the cycle after the clearing write and again in the cycle after that, to pin down both its timing and its one-cycle width.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
// Package: shared indices, bit positions and field masks for the RTC
// snapshot/commit controller. Assumes 8-bit registers.
package rtc_shadow_pkg;
    localparam int IDX_CTRL = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_DAY  = 4;

    localparam int CTL_SET_BIT    = 7;
    localparam int CTL_FREEZE_BIT = 6;

    // Time bits of each field; flag bits are excluded from mirroring.
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            IDX_SEC: return 8'h7F;
            IDX_DAY: return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
`timescale 1ns/1ps
// Control register: holds the freeze and set-time bits plus the
// calibration bits, and raises a one-cycle commit strobe when the
// set-time bit is cleared. Assumes wr_en_i is already decoded for index 0.
module rtc_ctrl_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic          freeze_o,
    output logic          set_o,
    output logic [DW-3:0] cal_o,
    output logic          commit_o
);
    import rtc_shadow_pkg::*;

    logic          freeze_q;
    logic          set_q;
    logic [DW-3:0] cal_q;
    logic          commit_q;

    // Capture control writes and detect the set-time falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            set_q    <= 1'b0;
            cal_q    <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (wr_en_i) begin
                freeze_q <= wdata_i[CTL_FREEZE_BIT];
                set_q    <= wdata_i[CTL_SET_BIT];
                cal_q    <= wdata_i[DW-3:0];
                if (set_q && !wdata_i[CTL_SET_BIT])
                    commit_q <= 1'b1;
            end
        end
    end

    assign freeze_o = freeze_q;
    assign set_o    = set_q;
    assign cal_o    = cal_q;
    assign commit_o = commit_q;

    // R5: a commit only follows a 1 -> 0 transition of the set-time bit.
    p_commit_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> (!set_q && $past(set_q)));
    // R5: the commit strobe lasts a single cycle.
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);
    // R10: control contents change only on a control write.
    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable({freeze_q, set_q, cal_q}));
endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
// Shadow bank: user copy of the time fields plus the stop, frequency-test
// and century-enable flags. Fields refresh from the live counters on a
// tick unless halted, and take host writes only while staging.
// Flags are kept apart from the fields and are writable at any time.
module rtc_shadow_bank #(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int NT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT*DW-1:0] live_time_i,
    input  logic             live_tick_i,
    input  logic             halt_i,
    input  logic             stage_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [NT*DW-1:0] time_o,
    output logic             stop_o,
    output logic             ft_o,
    output logic             ceb_o
);
    import rtc_shadow_pkg::*;

    function automatic logic [NT*DW-1:0] build_mask();
        logic [NT*DW-1:0] m;
        m = '0;
        for (int i = 0; i < NT; i++)
            m[i*DW +: DW] = DW'(field_mask(i + 1));
        return m;
    endfunction
    localparam logic [NT*DW-1:0] FULL_MASK = build_mask();

    logic stop_q, ft_q, ceb_q;

    genvar g;
    generate
        for (g = 0; g < NT; g++) begin : g_field
            localparam logic [DW-1:0] MASK = DW'(field_mask(g + 1));
            logic [DW-1:0] val_q;
            // Refresh from live counters, or take a staged host write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (live_tick_i && !halt_i)
                    val_q <= live_time_i[g*DW +: DW] & MASK;
                else if (stage_i && wr_en_i && addr_i == AW'(g + 1))
                    val_q <= wdata_i & MASK;
            end
            assign time_o[g*DW +: DW] = val_q;
        end
    endgenerate

    // Flags: written by any host write to their register, never refreshed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
            ceb_q  <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == AW'(IDX_SEC))
                stop_q <= wdata_i[7];
            if (addr_i == AW'(IDX_DAY)) begin
                ft_q  <= wdata_i[6];
                ceb_q <= wdata_i[5];
            end
        end
    end

    assign stop_o = stop_q;
    assign ft_o   = ft_q;
    assign ceb_o  = ceb_q;

    // R1: an unhalted tick loads every field from the live counters.
    p_refresh_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick_i && !halt_i) |=> (time_o == ($past(live_time_i) & FULL_MASK)));
    // R2: while halted and not staging a write, the fields do not move.
    p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !(stage_i && wr_en_i)) |=> $stable(time_o));
    // R8: the stop flag changes only through a write to the seconds index.
    p_stop_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == AW'(IDX_SEC)) |=> $stable(stop_q));
endmodule

// File: rtl/rtc_read_port.sv
`timescale 1ns/1ps
// Read port: assembles the register view (control, then the time fields
// with their flag bits laid over them) and registers the selected byte.
// Assumes NT + 1 register indices fit in AW bits.
module rtc_read_port #(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int NT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    ctrl_i,
    input  logic [NT*DW-1:0] time_i,
    input  logic             stop_i,
    input  logic             ft_i,
    input  logic             ceb_i,
    output logic [DW-1:0]    rdata_o
);
    import rtc_shadow_pkg::*;

    logic [DW-1:0] view [NT+1];
    logic [DW-1:0] sel;
    logic [DW-1:0] rdata_q;

    assign view[IDX_CTRL] = ctrl_i;

    genvar g;
    generate
        for (g = 1; g <= NT; g++) begin : g_view
            if (g == IDX_SEC) begin : g_sec
                assign view[g] = {stop_i, time_i[(g-1)*DW +: DW-1]};
            end else if (g == IDX_DAY) begin : g_day
                assign view[g] = {1'b0, ft_i, ceb_i, time_i[(g-1)*DW +: DW-3]};
            end else begin : g_plain
                assign view[g] = time_i[(g-1)*DW +: DW];
            end
        end
    endgenerate

    // Select the addressed byte.
    always_comb begin
        sel = view[addr_i];
    end

    // Register the read data on a read access only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en_i)
            rdata_q <= sel;
    end

    assign rdata_o = rdata_q;

    // R11: read data holds in cycles without a read access.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/rtc_shadow_ctrl.sv
`timescale 1ns/1ps
// Top: RTC register snapshot and load controller. Decodes the host bus,
// ties the control register, the shadow bank and the read port together,
// and exposes the commit strobe and the oscillator enable.
// Assumes live_tick_i is a single-cycle pulse from the counter chain.
module rtc_shadow_ctrl #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int N_TIME = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_cs_i,
    input  logic                     bus_we_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    input  logic [N_TIME*DATA_W-1:0] live_time_i,
    input  logic                     live_tick_i,
    output logic                     load_stb_o,
    output logic [N_TIME*DATA_W-1:0] load_time_o,
    output logic                     osc_en_o,
    output logic                     freq_test_o,
    output logic                     century_en_o,
    output logic [DATA_W-3:0]        cal_o
);
    import rtc_shadow_pkg::*;

    localparam int CAL_W = DATA_W - 2;

    logic              wr_any, rd_any, wr_ctrl;
    logic              freeze, set_time, commit;
    logic [CAL_W-1:0]  cal;
    logic [N_TIME*DATA_W-1:0] time_fields;
    logic              stop, ft, ceb;

    // Bus decode.
    assign wr_any  = bus_cs_i && bus_we_i;
    assign rd_any  = bus_cs_i && !bus_we_i;
    assign wr_ctrl = wr_any && (bus_addr_i == ADDR_W'(IDX_CTRL));

    rtc_ctrl_reg #(.DW(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_ctrl),
        .wdata_i  (bus_wdata_i),
        .freeze_o (freeze),
        .set_o    (set_time),
        .cal_o    (cal),
        .commit_o (commit)
    );

    rtc_shadow_bank #(.DW(DATA_W), .AW(ADDR_W), .NT(N_TIME)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_time_i (live_time_i),
        .live_tick_i (live_tick_i),
        .halt_i      (freeze || set_time),
        .stage_i     (set_time),
        .wr_en_i     (wr_any),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .time_o      (time_fields),
        .stop_o      (stop),
        .ft_o        (ft),
        .ceb_o       (ceb)
    );

    rtc_read_port #(.DW(DATA_W), .AW(ADDR_W), .NT(N_TIME)) rport_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_any),
        .addr_i  (bus_addr_i),
        .ctrl_i  ({set_time, freeze, cal}),
        .time_i  (time_fields),
        .stop_i  (stop),
        .ft_i    (ft),
        .ceb_i   (ceb),
        .rdata_o (bus_rdata_o)
    );

    assign load_stb_o   = commit;
    assign load_time_o  = time_fields;
    assign osc_en_o     = !stop;
    assign freq_test_o  = ft;
    assign century_en_o = ceb;
    assign cal_o        = cal;
endmodule

// File: tb/rtc_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares
// them against the registered read data; side outputs are checked inline.
module rtc_shadow_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [55:0] live = '0;
    logic        tick = 1'b0;
    logic        load_stb;
    logic [55:0] load_time;
    logic        osc_en, ft, ceb;
    logic [5:0]  cal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t exp_q[$];
    sb_item_t cur;
    logic rd_vld = 1'b0;

    always #2.5 clk = ~clk;

    rtc_shadow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_i(cs), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .live_time_i(live), .live_tick_i(tick),
        .load_stb_o(load_stb), .load_time_o(load_time),
        .osc_en_o(osc_en), .freq_test_o(ft), .century_en_o(ceb),
        .cal_o(cal)
    );

    function automatic logic [55:0] pack(input logic [7:0] s, mi, h, d, dt, mo, y);
        return {y, mo, dt, d, h, mi, s};
    endfunction

    // Marks which cycles carry fresh read data (R11: one cycle later).
    always @(posedge clk) rd_vld <= cs && !we;

    // Monitor: pop and compare each read result.
    always @(negedge clk) begin
        if (rd_vld) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected read data: actual %h expected none", rdata);
            end else begin
                cur = exp_q.pop_front();
                if (rdata !== cur.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", cur.tag, rdata, cur.exp);
                end
            end
        end
    end

    task automatic chk(input logic [55:0] act, input logic [55:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic pulse_tick(input logic [55:0] t);
        @(negedge clk);
        live = t; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    logic [55:0] ta, tb_v, tc;

    initial begin
        ta   = pack(8'h12, 8'h34, 8'h09, 8'h03, 8'h15, 8'h06, 8'h24);
        tb_v = pack(8'h27, 8'h35, 8'h10, 8'h04, 8'h16, 8'h07, 8'h25);
        tc   = pack(8'h50, 8'h36, 8'h11, 8'h05, 8'h17, 8'h08, 8'h26);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state.
        bus_rd(3'd0, 8'h00, "R7 control after reset");
        bus_rd(3'd1, 8'h00, "R7 seconds after reset");
        chk(osc_en, 1, "R7 osc_en after reset");
        chk(load_stb, 0, "R7 load strobe after reset");

        // R1: free-running refresh of all fields.
        pulse_tick(ta);
        for (int i = 1; i <= 7; i++)
            bus_rd(3'(i), ta[(i-1)*8 +: 8], $sformatf("R1 field %0d", i));

        // R3: freeze written in the same cycle as a tick.
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'h40;
        live = tb_v; tick = 1'b1;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; tick = 1'b0;
        bus_rd(3'd1, 8'h27, "R3 seconds updated despite freeze");
        bus_rd(3'd7, 8'h25, "R3 year updated despite freeze");

        // R2: frozen snapshot survives later ticks.
        pulse_tick(tc);
        bus_rd(3'd1, 8'h27, "R2 seconds frozen");
        bus_rd(3'd3, 8'h10, "R2 hours frozen");
        bus_rd(3'd0, 8'h40, "R2 control reads freeze");

        // R10 / R6: clear freeze, store calibration bits.
        bus_wr(3'd0, 8'h15);
        bus_rd(3'd0, 8'h15, "R10 control readback");
        chk(cal, 6'h15, "R10 cal_o");
        bus_rd(3'd1, 8'h27, "R6 no refresh before tick");
        pulse_tick(tc);
        bus_rd(3'd1, 8'h50, "R6 refresh on next tick");

        // R9: time writes ignored when not staging.
        bus_wr(3'd1, 8'h33);
        bus_wr(3'd2, 8'h44);
        bus_rd(3'd1, 8'h50, "R9 seconds write ignored");
        bus_rd(3'd2, 8'h36, "R9 minutes write ignored");

        // R4: staging under set-time.
        bus_wr(3'd0, 8'h80);
        bus_wr(3'd1, 8'h45);
        bus_wr(3'd2, 8'h59);
        bus_wr(3'd3, 8'h23);
        bus_wr(3'd4, 8'h07);
        bus_wr(3'd5, 8'h31);
        bus_wr(3'd6, 8'h12);
        bus_wr(3'd7, 8'h99);
        pulse_tick(tb_v);
        bus_rd(3'd1, 8'h45, "R4 staged seconds");
        bus_rd(3'd3, 8'h23, "R4 staged hours");
        bus_rd(3'd0, 8'h80, "R4 control reads set-time");

        // R5: commit strobe on clearing set-time.
        bus_wr(3'd0, 8'h00);
        chk(load_stb, 1, "R5 load strobe");
        chk(load_time, pack(8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99),
            "R5 load data");
        @(negedge clk);
        chk(load_stb, 0, "R5 strobe one cycle");

        pulse_tick(tc);
        bus_rd(3'd1, 8'h50, "R6 refresh after set-time clear");

        // R8: stop flag without set-time.
        bus_wr(3'd1, 8'h80);
        chk(osc_en, 0, "R8 osc stopped");
        bus_rd(3'd1, 8'hD0, "R8 stop flag readback");
        bus_wr(3'd1, 8'h00);
        chk(osc_en, 1, "R8 osc restarted");
        bus_rd(3'd1, 8'h50, "R9 seconds time bits untouched");

        // R9: frequency-test and century-enable flags.
        bus_wr(3'd4, 8'h60);
        chk(ft, 1, "R9 freq_test set");
        chk(ceb, 1, "R9 century_en set");
        bus_rd(3'd4, 8'h65, "R9 day with flags");
        pulse_tick(ta);
        bus_rd(3'd4, 8'h63, "R9 flags survive refresh");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 reads missing: actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule